// File: doc/BRIEF.md
# Set/Clear GPIO Bank

A bank of general-purpose I/O lines reached through a small word-addressed register port. Build-time parameters decide which registers exist: a level register that always reports the synchronized pin inputs, an optional write-one-to-set register, an optional write-one-to-clear register, and an optional direction register whose bits mean either "drive this line" or "float this line". Without a clear register, the set register loads the whole output latch. Without a set register, the level register loads it.

Toward the pads the block presents the raw input vector, an output-value vector and an output-enable vector, one bit per line. A line-count parameter trims the bank to its lowest lines, and an input-only option forbids the bank from ever driving anything. Inputs pass through a two-stage synchronizer before they become readable.

Top module: `gpio_setclr_bank`

## Requirements
- R1: During and after reset, with no write yet, `pin_out` is all zero and `bus_rdata` is zero. When a direction register is present, `pin_oe` is all zero, so every line is an input.
- R2: A read of word 0 (level) returns in bit n the level of `pin_in[n]` after two synchronizer stages. Data is valid in the cycle after `bus_rd` is sampled. A pin change becomes visible to a read sampled on the second clock edge after the change is sampled.
- R3: When both set and clear registers exist, writing word 1 (set) forces high every line whose data bit is 1 and leaves lines with a 0 bit unchanged.
- R4: Writing word 2 (clear) forces low every line whose data bit is 1 and leaves the others unchanged.
- R5: When the set register exists but the clear register does not, a write to word 1 loads the whole output latch, so 0 bits drive their lines low.
- R6: When no set register exists, a write to word 0 loads the whole output latch. When a set register exists, writes to word 0 do not change the outputs.
- R7: With the output-high direction variant (DIR_KIND=1), a write to word 3 sets `pin_oe` to the written bits. A read of word 3 returns them.
- R8: With the input-high direction variant (DIR_KIND=2), a 1 bit written to word 3 makes its line an input and a 0 bit makes it an output, so `pin_oe` is the inverse of the written bits. A read returns the bits in that same input-high sense, which is all ones after reset.
- R9: With no direction register (DIR_KIND=0), every used line is always output-enabled unless the bank is input-only. Word 3 reads zero and writes to it change nothing.
- R10: Write-data bits at and above NLINES are ignored, and read-data bits at and above NLINES are always 0.
- R11: With NO_DRIVE set, `pin_oe` and `pin_out` stay all zero whatever is written, and reads of word 1 return zero.
- R12: An absent set or clear register reads as zero, and a write to it changes neither `pin_out` nor `pin_oe`. Outputs change only on a write.
- R13: Reads of word 1, and of word 2 when present, return the current output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word select: 0 level, 1 set, 2 clear, 3 direction |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data, bit n for line n |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, updated the cycle after a read strobe |
| pin_in | input | NLINES | Asynchronous line levels from the pads |
| pin_out | output | NLINES | Output value per line |
| pin_oe | output | NLINES | Output enable per line, 1 = drive |

## Verification
Four instances run side by side on the same bus traffic: a full set/clear bank with an output-high direction register, a set-only bank with an input-high direction register, a level-register-only bank with no direction register, and an input-only bank. The same write then shows the OR-merge of the first, the whole-word load of the second, no effect on the third, and no effect on the fourth. The third instance reacts only to level-register writes, which separates the write-target decode of each variant. Directed patterns with all-ones upper data bits expose masking mistakes. A directed pin step read on consecutive cycles pins down the synchronizer depth. Seeded random writes and pin changes cover mixed set/clear/direction sequences.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_ADDR_W = 2;

   localparam logic [REG_ADDR_W-1:0] ADR_LEVEL = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADR_SET   = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADR_CLR   = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADR_DIR   = 2'd3;

   localparam int DIR_NONE   = 0;
   localparam int DIR_OUT_HI = 1;
   localparam int DIR_IN_HI  = 2;

   typedef struct packed {
      logic lvl;
      logic set;
      logic clr;
      logic dir;
   } wr_sel_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_in,
   output logic [N-1:0] sync_out
);
   logic [N-1:0] stage1_q;
   logic [N-1:0] stage2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= raw_in;
         stage2_q <= stage1_q;
      end
   end

   assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_state.sv
module gpio_out_state
   import gpio_pkg::*;
#(
   parameter int N        = 8,
   parameter bit HAS_SET  = 1'b1,
   parameter bit HAS_CLR  = 1'b1,
   parameter int DIR_KIND = DIR_OUT_HI,
   parameter bit NO_DRIVE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wr_sel_t      wsel,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] latch_val,
   output logic [N-1:0] oe_val,
   output logic [N-1:0] dir_view
);
   logic [N-1:0] lat_q;
   logic [N-1:0] lat_d;

   // Output latch update: the variant picks which word loads or merges.
   generate
      if (NO_DRIVE) begin : g_lat_off
         assign lat_d = '0;
      end else if (!HAS_SET) begin : g_lat_level
         always_comb begin
            lat_d = lat_q;
            if (wsel.lvl) lat_d = wbits;
         end
      end else if (HAS_CLR) begin : g_lat_setclr
         always_comb begin
            lat_d = lat_q;
            if (wsel.set) lat_d = lat_d | wbits;
            if (wsel.clr) lat_d = lat_d & ~wbits;
         end
      end else begin : g_lat_setload
         always_comb begin
            lat_d = lat_q;
            if (wsel.set) lat_d = wbits;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= lat_d;
   end

   assign latch_val = lat_q;

   // Direction storage: oe_q always holds "drive" sense internally.
   generate
      if (DIR_KIND == DIR_NONE) begin : g_nodir
         assign oe_val   = NO_DRIVE ? '0 : '1;
         assign dir_view = '0;
      end else begin : g_dir
         logic [N-1:0] oe_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        oe_q <= '0;
            else if (wsel.dir) oe_q <= (DIR_KIND == DIR_OUT_HI) ? wbits : ~wbits;
         end
         assign oe_val   = NO_DRIVE ? '0 : oe_q;
         assign dir_view = (DIR_KIND == DIR_OUT_HI) ? oe_q : ~oe_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
   import gpio_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N       = 8,
   parameter bit HAS_SET = 1'b1,
   parameter bit HAS_CLR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [N-1:0]          level,
   input  logic [N-1:0]          latch_val,
   input  logic [N-1:0]          dir_view,
   output logic [DATA_W-1:0]     rdata
);
   logic [N-1:0]      sel_bits;
   logic [DATA_W-1:0] rd_d;
   logic [DATA_W-1:0] rd_q;

   always_comb begin
      unique case (addr)
         ADR_LEVEL: sel_bits = level;
         ADR_SET:   sel_bits = HAS_SET ? latch_val : '0;
         ADR_CLR:   sel_bits = HAS_CLR ? latch_val : '0;
         default:   sel_bits = dir_view;
      endcase
      rd_d           = '0;
      rd_d[N-1:0]    = sel_bits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_d;
   end

   assign rdata = rd_q;
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
   import gpio_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NLINES   = 12,
   parameter bit HAS_SET  = 1'b1,
   parameter bit HAS_CLR  = 1'b1,
   parameter int DIR_KIND = DIR_OUT_HI,
   parameter bit NO_DRIVE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NLINES-1:0]     pin_in,
   output logic [NLINES-1:0]     pin_out,
   output logic [NLINES-1:0]     pin_oe
);
   // Elaboration-time parameter checks
   generate
      if (NLINES < 1 || NLINES > 63) begin : g_bad_lines
         $error("NLINES must lie in 1..63");
      end
      if (DATA_W > 64 || NLINES > DATA_W) begin : g_bad_width
         $error("DATA_W must be at most 64 and not below NLINES");
      end
      if (HAS_CLR && !HAS_SET) begin : g_bad_clr
         $error("a clear register needs a set register");
      end
      if (DIR_KIND < DIR_NONE || DIR_KIND > DIR_IN_HI) begin : g_bad_dir
         $error("DIR_KIND must be 0, 1 or 2");
      end
   endgenerate

   wr_sel_t           wsel;
   logic [NLINES-1:0] wbits;
   logic [NLINES-1:0] level;
   logic [NLINES-1:0] latch_val;
   logic [NLINES-1:0] oe_val;
   logic [NLINES-1:0] dir_view;
   logic              unused_wdata_hi;

   assign wbits           = bus_wdata[NLINES-1:0];
   assign unused_wdata_hi = ^bus_wdata;

   always_comb begin
      wsel     = '0;
      wsel.lvl = bus_wr && (bus_addr == ADR_LEVEL);
      wsel.set = bus_wr && (bus_addr == ADR_SET);
      wsel.clr = bus_wr && (bus_addr == ADR_CLR);
      wsel.dir = bus_wr && (bus_addr == ADR_DIR);
   end

   gpio_in_sync #(.N(NLINES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_in),
      .sync_out (level)
   );

   gpio_out_state #(
      .N        (NLINES),
      .HAS_SET  (HAS_SET),
      .HAS_CLR  (HAS_CLR),
      .DIR_KIND (DIR_KIND),
      .NO_DRIVE (NO_DRIVE)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wsel      (wsel),
      .wbits     (wbits),
      .latch_val (latch_val),
      .oe_val    (oe_val),
      .dir_view  (dir_view)
   );

   gpio_rd_port #(
      .DATA_W  (DATA_W),
      .N       (NLINES),
      .HAS_SET (HAS_SET),
      .HAS_CLR (HAS_CLR)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (bus_rd),
      .addr      (bus_addr),
      .level     (level),
      .latch_val (latch_val),
      .dir_view  (dir_view),
      .rdata     (bus_rdata)
   );

   assign pin_out = latch_val;
   assign pin_oe  = oe_val;
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
   import gpio_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NLINES   = 12,
   parameter bit HAS_SET  = 1'b1,
   parameter bit HAS_CLR  = 1'b1,
   parameter int DIR_KIND = DIR_OUT_HI,
   parameter bit NO_DRIVE = 1'b0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_ADDR_W-1:0] bus_addr,
   input logic                  bus_wr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic [DATA_W-1:0]     bus_rdata,
   input logic [NLINES-1:0]     pin_out,
   input logic [NLINES-1:0]     pin_oe
);
   assert_quiet_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      NO_DRIVE |-> (pin_oe == '0 && pin_out == '0));

   assert_set_merges_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SET && HAS_CLR && !NO_DRIVE && bus_wr && bus_addr == ADR_SET)
      |=> pin_out == ($past(pin_out) | $past(bus_wdata[NLINES-1:0])));

   assert_clr_merges_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_CLR && !NO_DRIVE && bus_wr && bus_addr == ADR_CLR)
      |=> pin_out == ($past(pin_out) & ~$past(bus_wdata[NLINES-1:0])));

   assert_set_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SET && !HAS_CLR && !NO_DRIVE && bus_wr && bus_addr == ADR_SET)
      |=> pin_out == $past(bus_wdata[NLINES-1:0]));

   assert_dir_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (DIR_KIND == DIR_OUT_HI && !NO_DRIVE && bus_wr && bus_addr == ADR_DIR)
      |=> pin_oe == $past(bus_wdata[NLINES-1:0]));

   assert_dir_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (DIR_KIND == DIR_IN_HI && !NO_DRIVE && bus_wr && bus_addr == ADR_DIR)
      |=> pin_oe == ~$past(bus_wdata[NLINES-1:0]));

   assert_only_writes_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

   generate
      if (NLINES < DATA_W) begin : g_hi
         assert_rdata_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:NLINES] == '0);
      end
   endgenerate
endmodule

bind gpio_setclr_bank gpio_setclr_chk #(
   .DATA_W   (DATA_W),
   .NLINES   (NLINES),
   .HAS_SET  (HAS_SET),
   .HAS_CLR  (HAS_CLR),
   .DIR_KIND (DIR_KIND),
   .NO_DRIVE (NO_DRIVE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_setclr_bank.sv
`timescale 1ns/1ps
module tb_gpio_setclr_bank;
   localparam int NV = 4;
   // variant 0: set+clr, out-high dir; 1: set only, in-high dir;
   // 2: level only, no dir; 3: input-only
   localparam int NL   [NV] = '{12, 8, 5, 12};
   localparam bit VSET [NV] = '{1'b1, 1'b1, 1'b0, 1'b1};
   localparam bit VCLR [NV] = '{1'b1, 1'b0, 1'b0, 1'b1};
   localparam int VDIR [NV] = '{1, 2, 0, 1};
   localparam bit VRO  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] pin_src = '0;

   logic [31:0] rd_a  [NV];
   logic [31:0] out_a [NV];
   logic [31:0] oe_a  [NV];

   logic [31:0] m_lat [NV];
   logic [31:0] m_oe  [NV];

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   logic [31:0] rd0, rd1, rd2, rd3;
   logic [11:0] po0, oe0, po3, oe3;
   logic [7:0]  po1, oe1;
   logic [4:0]  po2, oe2;

   gpio_setclr_bank #(.DATA_W(32), .NLINES(12), .HAS_SET(1'b1), .HAS_CLR(1'b1),
                      .DIR_KIND(1), .NO_DRIVE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd0),
      .pin_in(pin_src[11:0]), .pin_out(po0), .pin_oe(oe0));

   gpio_setclr_bank #(.DATA_W(32), .NLINES(8), .HAS_SET(1'b1), .HAS_CLR(1'b0),
                      .DIR_KIND(2), .NO_DRIVE(1'b0)) dut_nc (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd1),
      .pin_in(pin_src[7:0]), .pin_out(po1), .pin_oe(oe1));

   gpio_setclr_bank #(.DATA_W(32), .NLINES(5), .HAS_SET(1'b0), .HAS_CLR(1'b0),
                      .DIR_KIND(0), .NO_DRIVE(1'b0)) dut_lv (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd2),
      .pin_in(pin_src[4:0]), .pin_out(po2), .pin_oe(oe2));

   gpio_setclr_bank #(.DATA_W(32), .NLINES(12), .HAS_SET(1'b1), .HAS_CLR(1'b1),
                      .DIR_KIND(1), .NO_DRIVE(1'b1)) dut_ro (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd3),
      .pin_in(pin_src[11:0]), .pin_out(po3), .pin_oe(oe3));

   always_comb begin
      rd_a[0] = rd0; out_a[0] = {20'd0, po0}; oe_a[0] = {20'd0, oe0};
      rd_a[1] = rd1; out_a[1] = {24'd0, po1}; oe_a[1] = {24'd0, oe1};
      rd_a[2] = rd2; out_a[2] = {27'd0, po2}; oe_a[2] = {27'd0, oe2};
      rd_a[3] = rd3; out_a[3] = {20'd0, po3}; oe_a[3] = {20'd0, oe3};
   end

   function automatic logic [31:0] msk(int n);
      return (32'd1 << n) - 32'd1;
   endfunction

   function automatic logic [31:0] exp_oe(int k);
      if (VRO[k]) return '0;
      if (VDIR[k] == 0) return msk(NL[k]);
      return m_oe[k];
   endfunction

   function automatic logic [31:0] exp_rd(int k, logic [1:0] a);
      case (a)
         2'd0: return pin_src & msk(NL[k]);
         2'd1: return VSET[k] ? m_lat[k] : 32'd0;
         2'd2: return VCLR[k] ? m_lat[k] : 32'd0;
         default: begin
            if (VDIR[k] == 0) return 32'd0;
            if (VDIR[k] == 1) return m_oe[k];
            return ~m_oe[k] & msk(NL[k]);
         end
      endcase
   endfunction

   task automatic check(string tag, int k, logic [31:0] act, logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s variant %0d: actual %h expected %h", tag, k, act, expv);
      end
   endtask

   task automatic check_pins(string tag);
      for (int k = 0; k < NV; k++) begin
         check({tag, " pin_out"}, k, out_a[k], m_lat[k]);
         check({tag, " pin_oe"},  k, oe_a[k],  exp_oe(k));
      end
   endtask

   task automatic model_write(logic [1:0] a, logic [31:0] d);
      for (int k = 0; k < NV; k++) begin
         logic [31:0] wb;
         wb = d & msk(NL[k]);
         case (a)
            2'd0: if (!VSET[k]) m_lat[k] = wb;
            2'd1: if (VSET[k]) m_lat[k] = VCLR[k] ? (m_lat[k] | wb) : wb;
            2'd2: if (VCLR[k]) m_lat[k] = m_lat[k] & ~wb;
            default: if (VDIR[k] != 0) m_oe[k] = (VDIR[k] == 1) ? wb : (~wb & msk(NL[k]));
         endcase
         if (VRO[k]) m_lat[k] = '0;
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [31:0] d, string tag);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
      check_pins(tag);
   endtask

   task automatic bus_read(logic [1:0] a, string tag);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
      for (int k = 0; k < NV; k++) check({tag, " rdata"}, k, rd_a[k], exp_rd(k, a));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] old_pins;
      void'($urandom(32'd20240611));
      for (int k = 0; k < NV; k++) begin m_lat[k] = '0; m_oe[k] = '0; end
      pin_src = 32'hFFFF_FFFF;
      @(negedge clk); @(negedge clk); @(negedge clk);
      // R1: reset state (no-direction variant drives all lines: R9)
      check_pins("R1 R9 reset");
      for (int k = 0; k < NV; k++) check("R1 rdata", k, rd_a[k], 32'd0);
      rst_n = 1'b1;
      idle(3);
      check_pins("R1 after release");
      // R8: input-high direction reads all ones after reset
      bus_read(2'd3, "R8 R7 R9 dir reset read");
      // R2 R10: pins all high, upper data bits must be zero
      bus_read(2'd0, "R2 R10 level");
      // R3 R5 R11 R6: set write with junk in upper bits
      bus_write(2'd1, 32'hFFFF_F0A5, "R3 R5 R11 R6 R10 set");
      bus_write(2'd1, 32'h0000_0300, "R3 R5 set merge-vs-load");
      bus_read(2'd1, "R13 R11 R12 set read");
      // R4: clear merge; R12: clear absent in set-only variant
      bus_write(2'd2, 32'hFFFF_F001, "R4 R12 clear");
      bus_read(2'd2, "R13 R12 clear read");
      // R6: level-register write
      bus_write(2'd0, 32'hFFFF_FFEA, "R6 level write");
      bus_write(2'd0, 32'h0000_0015, "R6 level write 2");
      // R7 R8 R9 R11: direction writes
      bus_write(2'd3, 32'hFFFF_F0F0, "R7 R8 R9 R11 dir");
      bus_read(2'd3, "R7 R8 R9 dir read");
      bus_write(2'd3, 32'h0000_0000, "R7 R8 dir zero");
      idle(2);
      check_pins("R12 idle");
      // R2: synchronizer depth
      pin_src = 32'h0000_0000;
      idle(3);
      old_pins = pin_src;
      pin_src = 32'h0000_0A5A;
      bus_addr = 2'd0; bus_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      for (int k = 0; k < NV; k++) check("R2 first edge", k, rd_a[k], old_pins & msk(NL[k]));
      @(posedge clk); @(negedge clk);
      for (int k = 0; k < NV; k++) check("R2 second edge", k, rd_a[k], old_pins & msk(NL[k]));
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
      for (int k = 0; k < NV; k++) check("R2 third edge", k, rd_a[k], pin_src & msk(NL[k]));
      // Random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         op = int'($urandom_range(0, 2));
         if (op == 0) begin
            bus_write(2'($urandom_range(0, 3)), $urandom, "R3 R4 R5 R6 R7 R8 random write");
         end else if (op == 1) begin
            pin_src = $urandom;
            idle(3);
            bus_read(2'd0, "R2 R10 random level");
         end else begin
            bus_read(2'($urandom_range(0, 3)), "R13 R12 random read");
         end
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule